// File: doc/BRIEF.md
# SDRAM Refresh Pacer with Deferred Catch-Up

This block decides when a memory controller should issue AUTO REFRESH commands to a synchronous DRAM. Every array row has to be refreshed within the retention period. The block therefore divides that period into equal nominal slots. Each expired slot adds one owed refresh to a debt counter.

The controller may defer refreshes while it is busy with traffic. When it goes idle, it pays the debt back as a quick series of refreshes. Successive refreshes in that series are held apart by the refresh cycle time. The block also raises an urgent request that the controller must honour even when busy. It does so in two cases: when the debt comes close to its cap, or when the time since the last refresh nears the longest allowed spacing of eight nominal slots.

All timing advances on a pacing strobe `tick_i`, with one strobe per `TICK_PS` picoseconds. The controller reports each refresh it has actually issued by pulsing `ack_i` for one cycle.

Top module: `rfsh_pacer`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_o` and `urgent_o` are 0. The debt, the slot timer, the spacing timer and the since-last-refresh timer all start from zero.
- R2: One refresh is owed every `SLOT` strobes, where `SLOT = floor(REFI_PS / TICK_PS)`. The first one is owed after the `SLOT`-th strobe following reset, and the debt grows by at most one per cycle.
- R3: `req_o` is 1 exactly when three things hold: the debt is nonzero, `busy_i` is 0, and the spacing window has elapsed.
- R4: An accepted acknowledge is `ack_i` = 1 while the debt is nonzero. It lowers the debt by one. It also holds both `req_o` and `urgent_o` low for `RFC` strobes, where `RFC = ceil(RFC_PS / TICK_PS)`, with a minimum of 1.
- R5: The debt never exceeds `MAX_DEBT`, which defaults to 8. A slot expiring at the cap is dropped, so a full debt is cleared by exactly `MAX_DEBT` acknowledges.
- R6: `urgent_o` is 1 whenever the debt is at least `URGENT_DEBT` (default 7) and the spacing window has elapsed, whatever the value of `busy_i`.
- R7: `urgent_o` is also 1 when the debt is nonzero, the spacing window has elapsed, and the count of strobes since the last accepted acknowledge (or since reset) is at least `8*SLOT - GAP_MARGIN`.
- R8: `ack_i` while the debt is zero has no effect. It neither restarts the spacing window nor the since-last-refresh timer.
- R9: While `tick_i` is 0, no timer advances. The debt changes only through accepted acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Pacing strobe, one per `TICK_PS` |
| busy_i | input | 1 | Controller is busy and prefers to defer refresh |
| ack_i | input | 1 | One-cycle pulse: a refresh command was issued |
| req_o | output | 1 | Refresh owed and controller idle |
| urgent_o | output | 1 | Refresh must be issued before any other command |

## Verification
The bench builds the block with `TICK_PS` = 4000, `REFI_PS` = 160000 and `RFC_PS` = 10000, so a slot is 40 strobes and the spacing is 3 strobes. Rounding the spacing up (2.5 becomes 3) is therefore observable at the pins. `GAP_MARGIN` = 50 places the gap alarm at strobe 270. At that point the debt is only 6, so the gap-based urgent can be told apart from the debt-based one, which fires at strobe 280. With these values, a full debt of eight builds up in 320 strobes, and draining it fits inside one slot, so the saturation count is visible without interference from new slots.

// File: rtl/rfsh_pacer_pkg.sv
package rfsh_pacer_pkg;

   function automatic int unsigned div_up(input longint unsigned num,
                                          input longint unsigned den);
      return int'((num + den - 1) / den);
   endfunction

   function automatic int unsigned div_down(input longint unsigned num,
                                            input longint unsigned den);
      return int'(num / den);
   endfunction

   function automatic int unsigned at_least_one(input int unsigned v);
      return (v == 0) ? 1 : v;
   endfunction

   typedef enum logic [1:0] {
      DEBT_HOLD = 2'b00,
      DEBT_DEC  = 2'b01,
      DEBT_INC  = 2'b10,
      DEBT_BOTH = 2'b11
   } debt_op_e;

endpackage

// File: rtl/rfsh_slot_timer.sv
module rfsh_slot_timer #(
   parameter int unsigned SLOT = 1950,
   localparam int unsigned W   = (SLOT > 1) ? $clog2(SLOT) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   output logic due_o
);
   localparam logic [W-1:0] LAST = W'(SLOT - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign due_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter
   import rfsh_pacer_pkg::*;
#(
   parameter int unsigned MAX_DEBT = 8,
   localparam int unsigned W       = $clog2(MAX_DEBT + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         due_i,
   input  logic         take_i,
   output logic [W-1:0] debt_o,
   output logic         owed_o
);
   localparam logic [W-1:0] CAP = W'(MAX_DEBT);

   logic [W-1:0] debt_q;
   debt_op_e     op;

   assign op = debt_op_e'({due_i, take_i});

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         debt_q <= '0;
      end else begin
         unique case (op)
            DEBT_INC:  if (debt_q != CAP) debt_q <= debt_q + 1'b1;
            DEBT_DEC:  debt_q <= debt_q - 1'b1;
            DEBT_BOTH: debt_q <= debt_q;
            default:   debt_q <= debt_q;
         endcase
      end
   end

   assign debt_o = debt_q;
   assign owed_o = (debt_q != '0);
endmodule

// File: rtl/rfsh_space_timer.sv
module rfsh_space_timer #(
   parameter int unsigned RFC = 18,
   localparam int unsigned W  = $clog2(RFC + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         load_i,
   output logic         open_o,
   output logic [W-1:0] left_o
);
   localparam logic [W-1:0] LOAD = W'(RFC);

   logic [W-1:0] left_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         left_q <= '0;
      end else if (load_i) begin
         left_q <= LOAD;
      end else if (tick_i && (left_q != '0)) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign open_o = (left_q == '0);
   assign left_o = left_q;
endmodule

// File: rtl/rfsh_gap_timer.sv
module rfsh_gap_timer #(
   parameter int unsigned LIMIT = 15600,
   parameter int unsigned ALARM = 15536,
   parameter bit          USE_ALARM = 1'b1,
   localparam int unsigned W    = $clog2(LIMIT + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         clear_i,
   output logic         hot_o,
   output logic [W-1:0] age_o
);
   localparam logic [W-1:0] TOP = W'(LIMIT);
   localparam logic [W-1:0] THR = W'(ALARM);

   logic [W-1:0] age_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         age_q <= '0;
      end else if (clear_i) begin
         age_q <= '0;
      end else if (tick_i && (age_q != TOP)) begin
         age_q <= age_q + 1'b1;
      end
   end

   generate
      if (USE_ALARM) begin : g_alarm
         assign hot_o = (age_q >= THR);
      end else begin : g_no_alarm
         assign hot_o = 1'b0;
      end
   endgenerate

   assign age_o = age_q;
endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer
   import rfsh_pacer_pkg::*;
#(
   parameter int unsigned TICK_PS       = 4000,
   parameter int unsigned REFI_PS       = 7_800_000,
   parameter int unsigned RFC_PS        = 70_000,
   parameter int unsigned MAX_DEBT      = 8,
   parameter int unsigned URGENT_DEBT   = 7,
   parameter int unsigned GAP_SLOTS     = 8,
   parameter int unsigned GAP_MARGIN    = 64,
   parameter bit          GAP_ALARM_ON  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic busy_i,
   input  logic ack_i,
   output logic req_o,
   output logic urgent_o
);
   localparam int unsigned SLOT     = div_down(REFI_PS, TICK_PS);
   localparam int unsigned RFC      = at_least_one(div_up(RFC_PS, TICK_PS));
   localparam int unsigned GAP_LIM  = GAP_SLOTS * SLOT;
   localparam int unsigned GAP_THR  = (GAP_MARGIN < GAP_LIM) ? GAP_LIM - GAP_MARGIN : 0;
   localparam int unsigned DW       = $clog2(MAX_DEBT + 1);
   localparam int unsigned SW       = $clog2(RFC + 1);
   localparam int unsigned GW       = $clog2(GAP_LIM + 1);
   localparam logic [DW-1:0] URG_LV = DW'(URGENT_DEBT);

   generate
      if (TICK_PS == 0) begin : g_bad_tick
         $error("rfsh_pacer: TICK_PS must be nonzero");
      end
      if (SLOT < 2) begin : g_bad_slot
         $error("rfsh_pacer: slot must span at least two strobes");
      end
      if (MAX_DEBT < 1 || URGENT_DEBT > MAX_DEBT || URGENT_DEBT < 1) begin : g_bad_debt
         $error("rfsh_pacer: need 1 <= URGENT_DEBT <= MAX_DEBT");
      end
      if (GAP_SLOTS < MAX_DEBT) begin : g_bad_gap
         $error("rfsh_pacer: GAP_SLOTS must cover the debt cap");
      end
      if (GAP_MARGIN >= GAP_LIM) begin : g_bad_margin
         $error("rfsh_pacer: GAP_MARGIN must be below the gap limit");
      end
   endgenerate

   logic          due;
   logic          take;
   logic          owed;
   logic          open;
   logic          hot;
   logic [DW-1:0] debt_q;
   logic [SW-1:0] space_q;
   logic [GW-1:0] age_q;

   assign take = ack_i && owed;

   rfsh_slot_timer #(.SLOT(SLOT)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .due_o  (due)
   );

   rfsh_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .due_i  (due),
      .take_i (take),
      .debt_o (debt_q),
      .owed_o (owed)
   );

   rfsh_space_timer #(.RFC(RFC)) u_space (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .load_i (take),
      .open_o (open),
      .left_o (space_q)
   );

   rfsh_gap_timer #(
      .LIMIT     (GAP_LIM),
      .ALARM     (GAP_THR),
      .USE_ALARM (GAP_ALARM_ON)
   ) u_gap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .clear_i (take),
      .hot_o   (hot),
      .age_o   (age_q)
   );

   assign req_o    = owed && open && !busy_i;
   assign urgent_o = owed && open && ((debt_q >= URG_LV) || hot);

endmodule

// File: rtl/rfsh_pacer_chk.sv
module rfsh_pacer_chk #(
   parameter int unsigned MAX_DEBT    = 8,
   parameter int unsigned URGENT_DEBT = 7,
   parameter int unsigned GAP_LIM     = 15600,
   parameter int unsigned DW          = 4,
   parameter int unsigned SW          = 5,
   parameter int unsigned GW          = 14
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          tick_i,
   input logic          busy_i,
   input logic          ack_i,
   input logic          req_o,
   input logic          urgent_o,
   input logic [DW-1:0] debt_q,
   input logic [SW-1:0] space_q,
   input logic [GW-1:0] age_q
);
   a_r5_debt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(debt_q) <= MAX_DEBT);

   a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (32'(debt_q) <= 32'($past(debt_q)) + 1));

   a_r3_req_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |-> (!busy_i && debt_q != '0));

   a_r4_quiet_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && debt_q != '0) |=> (!req_o && !urgent_o));

   a_r6_urgent_on_debt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(debt_q) >= URGENT_DEBT && space_q == '0) |-> urgent_o);

   a_r7_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(age_q) <= GAP_LIM);

   a_r8_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && debt_q == '0 && !tick_i) |=> ($stable(debt_q) && $stable(age_q) && $stable(space_q)));

   a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !ack_i) |=> ($stable(debt_q) && $stable(age_q) && $stable(space_q)));
endmodule

bind rfsh_pacer rfsh_pacer_chk #(
   .MAX_DEBT    (MAX_DEBT),
   .URGENT_DEBT (URGENT_DEBT),
   .GAP_LIM     (GAP_LIM),
   .DW          (DW),
   .SW          (SW),
   .GW          (GW)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .tick_i   (tick_i),
   .busy_i   (busy_i),
   .ack_i    (ack_i),
   .req_o    (req_o),
   .urgent_o (urgent_o),
   .debt_q   (debt_q),
   .space_q  (space_q),
   .age_q    (age_q)
);

// File: tb/sim_rfsh_pacer.sv
`timescale 1ns/1ps
module sim_rfsh_pacer;
   logic clk = 1'b0;
   logic rst_n, tick, busy, ack;
   logic req, urgent;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #2 clk = ~clk;

   rfsh_pacer #(
      .TICK_PS    (4000),
      .REFI_PS    (160000),
      .RFC_PS     (10000),
      .GAP_MARGIN (50)
   ) u0 (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .tick_i   (tick),
      .busy_i   (busy),
      .ack_i    (ack),
      .req_o    (req),
      .urgent_o (urgent)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic tick_after, input logic busy_after);
      rst_n = 1'b0; tick = 1'b1; busy = 1'b0; ack = 1'b0;
      repeat (3) @(negedge clk);
      tick = tick_after; busy = busy_after;
   endtask

   task automatic release_reset();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset(1'b1, 1'b0);
      chk("R1 req in reset", int'(req), 0);
      chk("R1 urgent in reset", int'(urgent), 0);
      release_reset();
      edges(1);
      chk("R1 req after reset", int'(req), 0);
   endtask

   task automatic t_first_slot();
      do_reset(1'b1, 1'b0);
      release_reset();
      edges(39);
      chk("R2 before first slot", int'(req), 0);
      edges(1);
      chk("R2 at first slot", int'(req), 1);
   endtask

   task automatic t_freeze();
      do_reset(1'b0, 1'b0);
      release_reset();
      edges(100);
      chk("R9 no strobes no debt", int'(req), 0);
      tick = 1'b1;
      edges(39);
      chk("R9 timer resumed not early", int'(req), 0);
      edges(1);
      chk("R9 timer resumed on time", int'(req), 1);
   endtask

   task automatic t_spacing();
      do_reset(1'b1, 1'b1);
      release_reset();
      edges(80);
      chk("R3 busy blocks req", int'(req), 0);
      chk("R3 urgent low at debt 2", int'(urgent), 0);
      busy = 1'b0;
      #1;
      chk("R3 idle raises req", int'(req), 1);
      ack = 1'b1;
      edges(1);
      ack = 1'b0;
      chk("R4 req low after ack", int'(req), 0);
      edges(1);
      chk("R4 still spacing", int'(req), 0);
      edges(2);
      chk("R4 spacing elapsed", int'(req), 1);
      ack = 1'b1;
      edges(1);
      ack = 1'b0;
      edges(4);
      chk("R4 debt paid off", int'(req), 0);
   endtask

   task automatic t_stray_ack();
      do_reset(1'b1, 1'b0);
      release_reset();
      edges(39);
      ack = 1'b1;
      edges(1);
      ack = 1'b0;
      chk("R8 stray ack no spacing", int'(req), 1);
   endtask

   task automatic t_cap();
      int acks = 0;
      do_reset(1'b1, 1'b1);
      release_reset();
      edges(360);
      chk("R6 urgent at full debt", int'(urgent), 1);
      busy = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (req && !ack) begin
            ack = 1'b1;
            acks++;
         end else begin
            ack = 1'b0;
         end
      end
      ack = 1'b0;
      chk("R5 acks to drain cap", acks, 8);
      chk("R5 drained", int'(req), 0);
   endtask

   task automatic t_urgent_debt();
      do_reset(1'b1, 1'b1);
      release_reset();
      edges(241);
      ack = 1'b1;
      edges(1);
      ack = 1'b0;
      edges(77);
      chk("R6 debt 6 not urgent", int'(urgent), 0);
      edges(1);
      chk("R6 debt 7 urgent", int'(urgent), 1);
      chk("R6 busy still blocks req", int'(req), 0);
   endtask

   task automatic t_urgent_gap();
      do_reset(1'b1, 1'b1);
      release_reset();
      edges(269);
      chk("R7 gap below alarm", int'(urgent), 0);
      edges(1);
      chk("R7 gap alarm at debt 6", int'(urgent), 1);
      ack = 1'b1;
      edges(1);
      ack = 1'b0;
      edges(4);
      chk("R7 alarm cleared by refresh", int'(urgent), 0);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; tick = 1'b0; busy = 1'b0; ack = 1'b0;
      t_reset();
      t_first_slot();
      t_freeze();
      t_spacing();
      t_stray_ack();
      t_cap();
      t_urgent_debt();
      t_urgent_gap();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         report();
      end
   end
endmodule